// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C bus target that gives a host access to a small set of registers through a stored pointer. SCL and SDA are sampled with the system clock through synchronisers, and the block finds START, repeated START and STOP conditions from the sampled lines. It answers one 7-bit address. The upper four bits of that address are a parameter and the lower three come from pins. The block drives SDA only by pulling it low through an output enable, so the line stays open-drain.

A write carries a pointer byte and then optional data bytes. A read returns the register that the pointer last selected. The host can therefore set the pointer and read back in one transaction, using a repeated START, or read again later without sending a pointer byte. The register set has mixed widths: a read-only 16-bit sample input, an 8-bit control register (a low-power halt bit and a 2-bit fault-count code), and two 16-bit writable limit words. The block pulses a write strobe when a register takes a new value. It pulses a read strobe once when a read ends, so that logic alongside can clear a latched alarm.

Top module: `i2c_ptr_target`

## Requirements
- R1: The target acknowledges only the address byte {ADDR_HI = 4'b1001, pin_addr_i[2:0], r/w}, where r/w = 0 means write. It acknowledges by pulling SDA low during the 9th clock. A non-matching address is not acknowledged, and the bytes after it are neither acknowledged nor able to change the pointer or any register, until the next START.
- R2: Each byte takes nine SCL clocks: eight data bits with the MSB first, then an acknowledge bit. The target changes its SDA drive only while SCL is low.
- R3: A START or repeated START restarts address reception from any bit position. A byte cut short this way has no effect. A STOP returns the target to idle with SDA released.
- R4: In a write, the first byte after the address is the pointer. It is acknowledged, and its bits 1:0 select the register: 0 is the sample input (16-bit, read-only), 1 is control (8-bit), 2 is the lower limit (16-bit) and 3 is the upper limit (16-bit). ptr_o shows the stored pointer.
- R5: Data bytes are acknowledged. The control register takes the first data byte. A 16-bit register takes the high byte and then the low byte, and changes only after the second byte. wr_stb_o pulses for one cycle when a register changes. Further bytes, and writes to pointer 0, are acknowledged and discarded.
- R6: A read address uses the pointer stored by the most recent pointer byte, whether that byte came in the same transaction before a repeated START or in an earlier one.
- R7: A 16-bit read returns the high byte first. The low byte follows only if the host acknowledges. Both bytes come from one 16-bit value that is captured when the read address is acknowledged.
- R8: After the last byte the target supplies (the low byte, the only byte of the control register, or any byte the host does not acknowledge), SDA stays released. rd_stb_o pulses once, at the end of that acknowledge slot.
- R9: After reset the pointer is 0, control is 8'h00, the lower limit is 16'h4B00, the upper limit is 16'h5000 and SDA is released.
- R10: Control bit 0 drives halt_o and control bits 4:3 drive fq_code_o. Register reads and writes still work while halt_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| pin_addr_i | input | 3 | Low three address bits |
| sample_i | input | 16 | Read-only value returned at pointer 0 |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| ctrl_o | output | 8 | Control register |
| lo_lim_o | output | 16 | Lower limit register |
| hi_lim_o | output | 16 | Upper limit register |
| ptr_o | output | 2 | Stored pointer |
| halt_o | output | 1 | Control bit 0 |
| fq_code_o | output | 2 | Control bits 4:3 |
| wr_stb_o | output | 1 | One-cycle pulse when a register changes |
| rd_stb_o | output | 1 | One-cycle pulse when a read ends |

## Verification
Two things can happen on the same sampled edge. The condition detector can see a START while the byte sequencer holds a partly shifted byte. The sample input can also change between the capture for the high byte and the transmission of the low byte. The bench provokes the first by sending half a pointer byte and then a repeated START with a read address. It passes only if the pointer is unchanged and the read returns the pointer-0 value. It provokes the second by changing sample_i after the host has acknowledged the high byte. It passes only if the low byte still comes from the word captured earlier.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PTR_W  = 2;

  localparam logic [PTR_W-1:0] PTR_SAMPLE = 2'd0;
  localparam logic [PTR_W-1:0] PTR_CTRL   = 2'd1;
  localparam logic [PTR_W-1:0] PTR_LOLIM  = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] cur;
  logic [NLINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= cur;
  end

  // bit 1 = SCL, bit 0 = SDA
  assign scl_rise  =  cur[1] & ~prev[1];
  assign scl_fall  = ~cur[1] &  prev[1];
  assign start_det =  cur[1] &  prev[1] &  prev[0] & ~cur[0];
  assign stop_det  =  cur[1] &  prev[1] & ~prev[0] &  cur[0];
  assign sda_lvl   =  cur[0];
endmodule

// File: rtl/i2c_tgt_seq.sv
module i2c_tgt_seq
  import i2c_tgt_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic [2:0]        pin_addr,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rd_two,
  output logic              sda_oe,
  output logic              ptr_we,
  output logic              wr_byte_stb,
  output logic [BYTE_W-1:0] byte_d,
  output logic [1:0]        wr_idx,
  output logic              rd_stb
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  tgt_state_e        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] sreg;
  logic [BYTE_W-1:0] txreg;
  logic [BYTE_W-1:0] snap_lo;
  logic [1:0]        bidx;
  logic              rw;
  logic              two;
  logic              host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      sreg        <= '0;
      txreg       <= '0;
      snap_lo     <= '0;
      bidx        <= '0;
      rw          <= 1'b0;
      two         <= 1'b0;
      host_ack    <= 1'b0;
      sda_oe      <= 1'b0;
      ptr_we      <= 1'b0;
      wr_byte_stb <= 1'b0;
      byte_d      <= '0;
      wr_idx      <= '0;
      rd_stb      <= 1'b0;
    end else begin
      ptr_we      <= 1'b0;
      wr_byte_stb <= 1'b0;
      rd_stb      <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && bitcnt < LAST_BIT) begin
              sreg   <= {sreg[BYTE_W-2:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (sreg[7:1] == {ADDR_HI, pin_addr}) begin
                  sda_oe <= 1'b1;
                  rw     <= sreg[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state  <= ST_IGNORE;
                end
              end else if (state == ST_PTR) begin
                sda_oe <= 1'b1;
                ptr_we <= 1'b1;
                byte_d <= sreg;
                bidx   <= '0;
                state  <= ST_PTR_ACK;
              end else begin
                sda_oe      <= 1'b1;
                wr_byte_stb <= 1'b1;
                byte_d      <= sreg;
                wr_idx      <= bidx;
                if (bidx != 2'd3) bidx <= bidx + 2'd1;
                state       <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                txreg   <= rd_word[WORD_W-1:BYTE_W];
                snap_lo <= rd_word[BYTE_W-1:0];
                two     <= rd_two;
                sda_oe  <= ~rd_word[WORD_W-1];
                bidx    <= '0;
                state   <= ST_RDATA;
              end else begin
                sda_oe  <= 1'b0;
                state   <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RACK;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (host_ack && two && bidx == 2'd0) begin
                txreg  <= snap_lo;
                sda_oe <= ~snap_lo[BYTE_W-1];
                bidx   <= 2'd1;
                state  <= ST_RDATA;
              end else begin
                rd_stb <= 1'b1;
                state  <= ST_IGNORE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CTRL_RST  = 8'h00,
  parameter logic [WORD_W-1:0] LOLIM_RST = 16'h4B00,
  parameter logic [WORD_W-1:0] HILIM_RST = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_we,
  input  logic              wr_byte_stb,
  input  logic [BYTE_W-1:0] byte_d,
  input  logic [1:0]        wr_idx,
  input  logic [WORD_W-1:0] sample,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] ctrl,
  output logic [WORD_W-1:0] lo_lim,
  output logic [WORD_W-1:0] hi_lim,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_two,
  output logic              wr_stb
);
  localparam int unsigned NWORDS = 2;
  localparam logic [NWORDS*WORD_W-1:0] WORD_RST = {HILIM_RST, LOLIM_RST};

  logic [BYTE_W-1:0]        hold;
  logic [NWORDS*WORD_W-1:0] words;
  logic [NWORDS-1:0]        word_commit;
  logic                     ctrl_commit;
  logic                     wide_sel;

  assign wide_sel    = ptr >= PTR_LOLIM;
  assign ctrl_commit = wr_byte_stb && wr_idx == 2'd0 && ptr == PTR_CTRL;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      ctrl <= CTRL_RST;
      hold <= '0;
    end else begin
      if (ptr_we) ptr <= byte_d[PTR_W-1:0];
      if (ctrl_commit) ctrl <= byte_d;
      if (wr_byte_stb && wr_idx == 2'd0 && wide_sel) hold <= byte_d;
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [PTR_W-1:0] MY_PTR = PTR_W'(PTR_LOLIM + i);
    logic [WORD_W-1:0] wq;
    assign word_commit[i] = wr_byte_stb && wr_idx == 2'd1 && ptr == MY_PTR;
    always_ff @(posedge clk) begin
      if (rst)                 wq <= WORD_RST[i*WORD_W +: WORD_W];
      else if (word_commit[i]) wq <= {hold, byte_d};
    end
    assign words[i*WORD_W +: WORD_W] = wq;
  end

  always_ff @(posedge clk) begin
    if (rst) wr_stb <= 1'b0;
    else     wr_stb <= ctrl_commit | (|word_commit);
  end

  assign lo_lim = words[WORD_W-1:0];
  assign hi_lim = words[2*WORD_W-1:WORD_W];

  always_comb begin
    case (ptr)
      PTR_SAMPLE: rd_word = sample;
      PTR_CTRL:   rd_word = {ctrl, {BYTE_W{1'b0}}};
      PTR_LOLIM:  rd_word = lo_lim;
      default:    rd_word = hi_lim;
    endcase
  end

  assign rd_two = ptr != PTR_CTRL;
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [3:0]        ADDR_HI     = 4'b1001,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CTRL_RST    = 8'h00,
  parameter logic [WORD_W-1:0] LOLIM_RST   = 16'h4B00,
  parameter logic [WORD_W-1:0] HILIM_RST   = 16'h5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        pin_addr_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] lo_lim_o,
  output logic [WORD_W-1:0] hi_lim_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              halt_o,
  output logic [1:0]        fq_code_o,
  output logic              wr_stb_o,
  output logic              rd_stb_o
);
  logic              scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic              ptr_we, wr_byte_stb, rd_two;
  logic [BYTE_W-1:0] byte_d;
  logic [1:0]        wr_idx;
  logic [WORD_W-1:0] rd_word;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl)
  );

  i2c_tgt_seq #(.ADDR_HI(ADDR_HI)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_lvl     (sda_lvl),
    .pin_addr    (pin_addr_i),
    .rd_word     (rd_word),
    .rd_two      (rd_two),
    .sda_oe      (sda_oe_o),
    .ptr_we      (ptr_we),
    .wr_byte_stb (wr_byte_stb),
    .byte_d      (byte_d),
    .wr_idx      (wr_idx),
    .rd_stb      (rd_stb_o)
  );

  i2c_tgt_regs #(
    .CTRL_RST  (CTRL_RST),
    .LOLIM_RST (LOLIM_RST),
    .HILIM_RST (HILIM_RST)
  ) i_regs (
    .clk         (clk),
    .rst         (rst),
    .ptr_we      (ptr_we),
    .wr_byte_stb (wr_byte_stb),
    .byte_d      (byte_d),
    .wr_idx      (wr_idx),
    .sample      (sample_i),
    .ptr         (ptr_o),
    .ctrl        (ctrl_o),
    .lo_lim      (lo_lim_o),
    .hi_lim      (hi_lim_o),
    .rd_word     (rd_word),
    .rd_two      (rd_two),
    .wr_stb      (wr_stb_o)
  );

  assign halt_o    = ctrl_o[0];
  assign fq_code_o = ctrl_o[4:3];
endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk (
  input logic        clk,
  input logic        rst,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic [7:0]  ctrl_o,
  input logic [15:0] lo_lim_o,
  input logic [15:0] hi_lim_o,
  input logic        wr_stb_o,
  input logic        rd_stb_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_i); // R2

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o); // R5

  AST_CTRL_STROBED: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_o) |-> wr_stb_o); // R5

  AST_LIM_STROBED: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lo_lim_o) || !$stable(hi_lim_o)) |-> wr_stb_o); // R5

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_stb_o |=> !rd_stb_o); // R8

  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rd_stb_o |-> !sda_oe_o); // R8
endmodule

bind i2c_ptr_target i2c_ptr_target_chk i_chk (.*);

// File: tb/test_i2c_ptr_target.sv
`timescale 1ns/1ps
module test_i2c_ptr_target;
  localparam time TCLK = 5ns;
  localparam time Q    = 40ns;
  localparam logic [7:0] AW = 8'h9A, AR = 8'h9B, ABAD = 8'h98;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic [15:0] sample = 16'h0000;
  logic sda_oe, halt, wr_stb, rd_stb, sda_line;
  logic [7:0] ctrl;
  logic [15:0] lo_lim, hi_lim;
  logic [1:0] ptr, fq;

  int n_run = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_byte;
  event       obs_ev;

  always #(TCLK/2) clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  i2c_ptr_target i_i2c_ptr_target (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line), .pin_addr_i(3'b101),
    .sample_i(sample), .sda_oe_o(sda_oe), .ctrl_o(ctrl), .lo_lim_o(lo_lim),
    .hi_lim_o(hi_lim), .ptr_o(ptr), .halt_o(halt), .fq_code_o(fq),
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
  );

  always @(posedge clk) begin
    if (!rst && wr_stb) wr_cnt <= wr_cnt + 1;
    if (!rst && rd_stb) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(obs_ev) begin
    n_run++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected read byte: actual %0h expected none", obs_byte);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (obs_byte !== e) begin
        n_fail++;
        $display("FAIL %s read byte: actual %0h expected %0h", t, obs_byte, e);
      end
    end
  end

  task automatic push(input string t, input logic [7:0] b);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; #Q; scl_h = 1'b1; #Q; sda_h = 1'b0; #Q; scl_h = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; #Q; scl_h = 1'b1; #Q; sda_h = 1'b1; #Q;
  endtask

  task automatic put_bit(input logic b);
    sda_h = b; #Q; scl_h = 1'b1; #(2*Q); scl_h = 1'b0; #Q;
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; #Q; scl_h = 1'b1; #Q; b = sda_line; #Q; scl_h = 1'b0; #Q;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(ack_n);
  endtask

  task automatic rd_byte(input logic give_ack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    obs_byte = b;
    ->obs_ev;
    put_bit(~give_ack);
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    int w0, r0;
    repeat (10) @(posedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 oe", sda_oe, 0); chk("R9 ptr", ptr, 0); chk("R9 ctrl", ctrl, 8'h00);
    chk("R9 lolim", lo_lim, 16'h4B00); chk("R9 hilim", hi_lim, 16'h5000);

    // R6 R7 R8 preset pointer read of sample
    sample = 16'h1920; r0 = rd_cnt;
    bus_start(); wr_byte(AR, a); chk("R1 ack", a, 0);
    push("R7 hi", 8'h19); rd_byte(1'b1);
    push("R7 lo", 8'h20); rd_byte(1'b0);
    bus_stop(); chk("R8 rd strobe", rd_cnt - r0, 1);

    // R4 R5 R10 control write
    w0 = wr_cnt;
    bus_start(); wr_byte(AW, a); wr_byte(8'h01, a); chk("R4 ptr ack", a, 0);
    wr_byte(8'h19, a); chk("R5 data ack", a, 0); bus_stop();
    chk("R4 ptr", ptr, 1); chk("R5 ctrl", ctrl, 8'h19); chk("R5 wr strobe", wr_cnt - w0, 1);
    chk("R10 halt", halt, 1); chk("R10 fq", fq, 2'b11);

    // R6 R8 R10 read control via pointer + repeated start, while halted
    r0 = rd_cnt;
    bus_start(); wr_byte(AW, a); wr_byte(8'h01, a); bus_start();
    wr_byte(AR, a); chk("R6 rs ack", a, 0);
    push("R10 ctrl", 8'h19); rd_byte(1'b0); bus_stop();
    chk("R8 rd strobe ctrl", rd_cnt - r0, 1);

    // R8 host acks the only control byte: target releases afterwards
    r0 = rd_cnt;
    bus_start(); wr_byte(AR, a);
    push("R8 ctrl", 8'h19); rd_byte(1'b1);
    push("R8 released", 8'hFF); rd_byte(1'b0); bus_stop();
    chk("R8 single strobe", rd_cnt - r0, 1);

    // R5 16-bit write commits after second byte
    w0 = wr_cnt;
    bus_start(); wr_byte(AW, a); wr_byte(8'h02, a); wr_byte(8'h3C, a);
    chk("R5 hi byte held", lo_lim, 16'h4B00); chk("R5 no early strobe", wr_cnt - w0, 0);
    wr_byte(8'h80, a); bus_stop();
    chk("R5 lolim", lo_lim, 16'h3C80); chk("R5 strobe16", wr_cnt - w0, 1);

    // R6 preset read of lower limit
    bus_start(); wr_byte(AR, a);
    push("R6 hi", 8'h3C); rd_byte(1'b1); push("R6 lo", 8'h80); rd_byte(1'b0); bus_stop();

    // R5 write to pointer 0 discarded
    w0 = wr_cnt;
    bus_start(); wr_byte(AW, a); wr_byte(8'h00, a); wr_byte(8'h55, a);
    chk("R5 ro ack", a, 0); wr_byte(8'h66, a); bus_stop();
    chk("R5 ro no strobe", wr_cnt - w0, 0); chk("R4 ptr0", ptr, 0);

    // R1 wrong address ignored
    bus_start(); wr_byte(ABAD, a); chk("R1 nack", a, 1);
    wr_byte(8'h03, a); chk("R1 ignored byte", a, 1); wr_byte(8'h77, a); bus_stop();
    chk("R1 ptr kept", ptr, 0);

    // R7 coherence: sample changes between bytes
    sample = 16'hA1B2;
    bus_start(); wr_byte(AR, a);
    push("R7 coh hi", 8'hA1); rd_byte(1'b1);
    sample = 16'h0000;
    push("R7 coh lo", 8'hB2); rd_byte(1'b0); bus_stop();

    // R3 repeated start in mid pointer byte
    bus_start(); wr_byte(AW, a); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_start(); wr_byte(AR, a); chk("R3 restart ack", a, 0);
    push("R3 hi", 8'h00); rd_byte(1'b1); push("R3 lo", 8'h00); rd_byte(1'b0); bus_stop();
    chk("R3 ptr kept", ptr, 0);

    // R5 R10 extra byte to control discarded
    w0 = wr_cnt;
    bus_start(); wr_byte(AW, a); wr_byte(8'h01, a); wr_byte(8'h00, a); wr_byte(8'hAA, a);
    chk("R5 extra ack", a, 0); bus_stop();
    chk("R5 extra ctrl", ctrl, 8'h00); chk("R5 extra strobe", wr_cnt - w0, 1);
    chk("R10 halt clear", halt, 0);

    // R4 R6 upper limit write then read in one transaction
    bus_start(); wr_byte(AW, a); wr_byte(8'h03, a); wr_byte(8'h12, a); wr_byte(8'h34, a);
    bus_start(); wr_byte(AR, a);
    push("R6 hilim hi", 8'h12); rd_byte(1'b1); push("R6 hilim lo", 8'h34); rd_byte(1'b0);
    bus_stop();
    chk("R4 hilim", hi_lim, 16'h1234);
    repeat (4) @(negedge clk);
    chk("R3 released after stop", sda_oe, 0);
    chk("R7 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule